// File: doc/BRIEF.md
# Instruction Decode and Issue Stage with Scoreboard Interlock

This block is the decode step of a small in-order pipeline. It looks at the instruction at the head of the instruction queue and decodes it. It reads that instruction's source registers from a 32-entry register file that it owns, and it offers a decoded control bundle to the execute stage over a valid/ready handshake. The queue entry is popped in the same cycle that execute accepts it, so at most one instruction leaves decode per cycle, and instructions leave in queue order.

The pipeline has no forwarding. Decode keeps a scoreboard with one pending bit per register. The pending bit is raised when a register-writing instruction issues, and it is dropped when that register's result comes back on the write-back port. An instruction waits at the queue head while any source or its destination is pending. It also waits while execute is not ready.

A write-back that arrives in the same cycle as a read is seen by that read. The same write-back also clears the stall that it resolves, so a dependent instruction can issue in the cycle its operand arrives. Register 0 always reads as zero, and it cannot be written or made pending.

Top module: `issue_decode`

## Requirements
- R1: After reset every register reads as zero and no register is pending, so the first queued instruction issues at once when execute is ready.
- R2: `q_pop` is high in exactly the cycles where `iss_valid` and `iss_ready` are both high. At most one instruction is consumed per cycle, in queue order.
- R3: `iss_imm` is bits [15:0] of the instruction, sign-extended to 32 bits.
- R4: The instruction word is laid out as follows: opcode in bits [31:29], field A in [28:24], field B in [23:19], field C in [18:14]. `iss_opa` is the value of register B. `iss_opb` is the value of register A for store (5) and branch (6), and the value of register C for all other opcodes.
- R5: A write-back in the current cycle is returned by a read of that register in the same cycle. It also releases a stall on that register in the same cycle.
- R6: An instruction is held (`iss_valid` low) while one of its sources is pending. Sources are: B and C for add (0), sub (1) and mul (2); B for addi (3) and load (4); A and B for store (5) and branch (6); none for nop (7).
- R7: A register-writing instruction is also held while its destination A is pending.
- R8: While `iss_ready` is low, nothing is popped. The head instruction stays offered if it has no hazard.
- R9: Issuing opcodes 0 to 4 with A not equal to 0 sets A's pending bit. `iss_wr` is high and `iss_dst` equals A. Store, branch and nop set no bit, and they show `iss_wr` low and `iss_dst` equal to 0.
- R10: A write-back to register 0 has no effect. Register 0 reads as zero and never stalls. An opcode 0 to 4 with A equal to 0 issues with `iss_wr` low.
- R11: `iss_br` is high exactly when the issued opcode is branch (6).
- R12: `iss_op` carries the opcode bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 1 | Instruction queue holds an entry |
| q_instr | input | 32 | Instruction at the queue head |
| q_pop | output | 1 | Removes the head entry this cycle |
| iss_valid | output | 1 | Decoded bundle offered to execute |
| iss_ready | input | 1 | Execute can accept a bundle |
| iss_op | output | 3 | Opcode |
| iss_wr | output | 1 | Instruction writes a register |
| iss_dst | output | 5 | Destination register, 0 if none |
| iss_opa | output | 32 | First operand value |
| iss_opb | output | 32 | Second operand value |
| iss_imm | output | 32 | Sign-extended immediate |
| iss_br | output | 1 | Instruction is a branch |
| wb_en | input | 1 | Write-back valid |
| wb_addr | input | 5 | Write-back register |
| wb_data | input | 32 | Write-back value |

## Verification
The program opens with a directed chain that covers several cases:
- a negative immediate;
- a read-after-write on each operand slot;
- a store and a branch whose A field is the pending source;
- a mul that is both waiting on and overwriting the same register;
- a load aimed at register 0.

This chain separates a source hazard from a destination hazard, and it separates the store/branch operand mapping from the arithmetic one.

A long random stream over eight registers then runs with random execute back-pressure and random write-back latency. This makes write-back land in the same cycle as the stalled read, which separates correct same-cycle release from a stage that waits a cycle more. Stray write-backs to register 0, with random data, show whether register 0 can be altered or made to stall.

// File: rtl/issue_decode.sv
module issue_decode #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            q_valid,
  input  logic [31:0]     q_instr,
  output logic            q_pop,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [2:0]      iss_op,
  output logic            iss_wr,
  output logic [AW-1:0]   iss_dst,
  output logic [XLEN-1:0] iss_opa,
  output logic [XLEN-1:0] iss_opb,
  output logic [XLEN-1:0] iss_imm,
  output logic            iss_br,
  input  logic            wb_en,
  input  logic [AW-1:0]   wb_addr,
  input  logic [XLEN-1:0] wb_data
);

  localparam int TOP = 28;
  localparam logic [2:0] OP_MUL = 3'd2, OP_LW = 3'd4, OP_SW = 3'd5,
                         OP_BEQ = 3'd6, OP_NOP = 3'd7;

  logic [XLEN-1:0] rf [NREG];
  logic [NREG-1:0] pend;

  logic [2:0]    op;
  logic [AW-1:0] fa, fb, fc, s1, s2;
  logic          rtype, st_br, use1, use2, wrt, wbv, blk1, blk2, blkd;

  assign op    = q_instr[31:29];
  assign fa    = q_instr[TOP -: AW];
  assign fb    = q_instr[TOP-AW -: AW];
  assign fc    = q_instr[TOP-2*AW -: AW];

  assign rtype = op <= OP_MUL;
  assign st_br = (op == OP_SW) || (op == OP_BEQ);
  assign s1    = fb;
  assign s2    = st_br ? fa : fc;
  assign use1  = op != OP_NOP;
  assign use2  = rtype || st_br;
  assign wrt   = (op <= OP_LW) && (fa != '0);
  assign wbv   = wb_en && (wb_addr != '0);

  assign blk1  = use1 && pend[s1] && !(wbv && wb_addr == s1);
  assign blk2  = use2 && pend[s2] && !(wbv && wb_addr == s2);
  assign blkd  = wrt  && pend[fa] && !(wbv && wb_addr == fa);

  assign iss_valid = q_valid && !(blk1 || blk2 || blkd);
  assign q_pop     = iss_valid && iss_ready;
  assign iss_op    = op;
  assign iss_wr    = wrt;
  assign iss_dst   = wrt ? fa : '0;
  assign iss_br    = op == OP_BEQ;
  assign iss_imm   = {{(XLEN-16){q_instr[15]}}, q_instr[15:0]};

  always_comb begin
    iss_opa = '0;
    iss_opb = '0;
    if (s1 != '0) iss_opa = (wbv && wb_addr == s1) ? wb_data : rf[s1];
    if (s2 != '0) iss_opb = (wbv && wb_addr == s2) ? wb_data : rf[s2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (wbv) begin
        rf[wb_addr]   <= wb_data;
        pend[wb_addr] <= 1'b0;
      end
      if (q_pop && wrt) pend[fa] <= 1'b1;
    end
  end

  a_r9_sb_set: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && iss_wr) |=> pend[$past(iss_dst)]);

  a_r5_wb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_addr != '0 && !(q_pop && iss_wr && iss_dst == wb_addr))
      |=> !pend[$past(wb_addr)]);

  a_r6_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && use1 && pend[s1]) |-> (wb_en && wb_addr == s1));

  a_r7_no_waw: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && iss_wr && pend[iss_dst]) |-> (wb_en && wb_addr == iss_dst));

  a_r10_r0_free: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0]);

endmodule

// File: tb/sim_issue_decode.sv
`timescale 1ns/1ps
module sim_issue_decode;
  logic        clk = 0, rst_n = 0;
  logic        q_valid = 0, iss_ready = 0, wb_en = 0;
  logic [31:0] q_instr = 0, wb_data = 0;
  logic [4:0]  wb_addr = 0;
  logic        q_pop, iss_valid, iss_wr, iss_br;
  logic [2:0]  iss_op;
  logic [4:0]  iss_dst;
  logic [31:0] iss_opa, iss_opb, iss_imm;

  always #2.5 clk = ~clk;

  issue_decode u0 (.clk, .rst_n, .q_valid, .q_instr, .q_pop, .iss_valid,
    .iss_ready, .iss_op, .iss_wr, .iss_dst, .iss_opa, .iss_opb, .iss_imm,
    .iss_br, .wb_en, .wb_addr, .wb_data);

  localparam int N = 400;
  int nchk = 0, nbad = 0, cyc = 0, head = 0;
  logic [31:0] prog [N];
  logic [31:0] m_rf [32];
  bit          m_pend [32];
  int          wbq [$];
  bit          done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(int op, int a, int b, int c, logic [15:0] imm);
    return {op[2:0], a[4:0], b[4:0], c[4:0], 14'b0} | {16'b0, imm};
  endfunction

  function automatic logic [31:0] rd(int r);
    if (r == 0) return 0;
    if (wb_en && wb_addr == r) return wb_data;
    return m_rf[r];
  endfunction

  function automatic bit blocked(int r);
    return r != 0 && m_pend[r] && !(wb_en && wb_addr == r);
  endfunction

  task automatic step(bit pre, int paddr, logic [31:0] pdata, bit rchk);
    int op, a, b, c, s1, s2;
    bit u1, u2, wr, ev, ep;
    logic [31:0] ins;
    @(negedge clk);
    cyc++;
    q_valid = !pre && head < N;
    q_instr = q_valid ? prog[head] : 32'h0;
    iss_ready = pre ? 1'b1 : (($urandom % 4) != 0);
    if (pre) begin
      wb_en = 1; wb_addr = paddr[4:0]; wb_data = pdata;
    end else if (wbq.size() > 0 && ($urandom % 3) == 0) begin
      wb_en = 1; wb_addr = wbq[0][4:0]; wb_data = $urandom; void'(wbq.pop_front());
    end else if (($urandom % 8) == 0) begin
      wb_en = 1; wb_addr = 0; wb_data = $urandom;
    end else wb_en = 0;
    #1;
    ins = q_instr;
    op = ins[31:29]; a = ins[28:24]; b = ins[23:19]; c = ins[18:14];
    s1 = b; s2 = (op == 5 || op == 6) ? a : c;
    u1 = op != 7; u2 = op <= 2 || op == 5 || op == 6;
    wr = op <= 4 && a != 0;
    ev = q_valid && !((u1 && blocked(s1)) || (u2 && blocked(s2)) || (wr && blocked(a)));
    ep = ev && iss_ready;
    if (rchk) chk("R1", {31'b0, iss_valid}, 32'd1);
    chk("R6 R7 R9 valid", {31'b0, iss_valid}, {31'b0, ev});
    chk("R2 R8 pop", {31'b0, q_pop}, {31'b0, ep});
    if (ev) begin
      chk("R12 op", {29'b0, iss_op}, op);
      chk("R9 R10 wr", {31'b0, iss_wr}, {31'b0, wr});
      chk("R9 dst", {27'b0, iss_dst}, wr ? a : 0);
      chk("R4 R5 R10 opa", iss_opa, rd(s1));
      chk("R4 R5 R10 opb", iss_opb, rd(s2));
      chk("R3 imm", iss_imm, {{16{ins[15]}}, ins[15:0]});
      chk("R11 br", {31'b0, iss_br}, {31'b0, op == 6});
    end
    if (wb_en && wb_addr != 0) begin
      m_rf[wb_addr] = wb_data; m_pend[wb_addr] = 0;
    end
    if (ep) begin
      if (wr) begin m_pend[a] = 1; wbq.push_back(a); end
      head++;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin m_rf[i] = 0; m_pend[i] = 0; end
    prog[0] = enc(3, 1, 2, 0, 16'hFFFB);
    prog[1] = enc(0, 3, 1, 2, 16'h0);
    prog[2] = enc(5, 3, 1, 0, 16'h0004);
    prog[3] = enc(6, 3, 0, 0, 16'hFFFE);
    prog[4] = enc(2, 3, 3, 3, 16'h0);
    prog[5] = enc(4, 0, 1, 0, 16'h8000);
    prog[6] = enc(1, 4, 0, 3, 16'h0);
    prog[7] = enc(7, 5, 6, 7, 16'h7FFF);
    for (int i = 8; i < N; i++)
      prog[i] = enc($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, $urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    q_valid = 1; q_instr = enc(7, 0, 3, 4, 16'h0); iss_ready = 0; wb_en = 0;
    #1;
    chk("R1 valid after reset", {31'b0, iss_valid}, 32'd1);
    chk("R1 opa after reset", iss_opa, 32'd0);
    chk("R1 opb after reset", iss_opb, 32'd0);
    q_valid = 0;
    step(1, 0, 32'hDEADBEEF, 0);
    for (int r = 1; r < 32; r++) step(1, r, 32'h1000 * r + 7, 0);
    while (!done && (head < N || wbq.size() > 0)) step(0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule